// File: doc/BRIEF.md
# Single-Wire Multi-Master Bus Transmitter

This block is the sending and arbitration half of one node on a shared single-wire bus. The bus is wired-AND: a pull-up holds it high and any node may only pull it low. The node's output is an open-drain enable (`drive_low_o`, 1 pulls the wire low). Its input is the raw wire level, which is passed through a synchronizer before any decision depends on it.

When the user pulses `start_i`, the block latches a data word and waits until the synchronized wire has stayed high for a run of cycles. That run is the idle period plus a per-node priority wait, so nodes with a longer wait jump in later and yield to nodes with a shorter one. The block then sends a short probe: it drives low, then releases. Next it drives a long takeover low. Last, it sends the word MSB first as return-to-zero cells and releases the wire.

From the first probe cycle to the last data cell, every synchronized wire sample is compared with the level the node drove, delayed to match. Any difference releases the wire at once and reports a lost arbitration. The block does not retry; the user decides whether to start again.

Top module: `swb_tx`

## Requirements
- R1: After reset, `drive_low_o`, `busy_o`, `done_o` and `lost_o` are all 0.
- R2: A `start_i` pulse while not busy latches `data_i` and sets `busy_o` in the next cycle. A `start_i` pulse while busy is ignored: the word being sent and its waveform stay unchanged.
- R3: The probe begins only after the synchronized wire has been high for IDLE_CYC+PRIO_CYC consecutive cycles. Any low sample restarts the count, and no drive happens while the wire is held low.
- R4: The probe is PROBE_CYC cycles of `drive_low_o`=1 followed by PROBE_CYC cycles of `drive_low_o`=0.
- R5: The takeover follows the probe directly and is TAKE_CYC cycles of `drive_low_o`=1.
- R6: Data follows the takeover as DATA_W cells of 3*UNIT_CYC cycles each, MSB first. A 1 is UNIT_CYC cycles low then 2*UNIT_CYC high. A 0 is 2*UNIT_CYC low then UNIT_CYC high.
- R7: In the cycle after the final cell, `done_o` is 1 for exactly one cycle, `busy_o` is 0 and the wire is released. `busy_o` only falls together with `done_o` or `lost_o`.
- R8: If the synchronized wire differs from the delayed driven level during the probe, takeover or data, `lost_o` pulses for one cycle. In that same cycle `drive_low_o` and `busy_o` are 0, and no new attempt follows without a new `start_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to send one word |
| data_i | input | DATA_W | Word to send, sampled with start_i |
| bus_i | input | 1 | Raw wire level (asynchronous) |
| drive_low_o | output | 1 | Open-drain enable, 1 pulls the wire low |
| busy_o | output | 1 | Attempt in progress |
| done_o | output | 1 | One-cycle pulse, word sent |
| lost_o | output | 1 | One-cycle pulse, readback mismatch, wire released |

## Verification
The hardest case to reach is a readback mismatch while the node's own drive is low. On a real wired-AND bus another node can only pull low, so the wire never reads high against a low drive. The bench models the wire as the AND of the block's drive and a second node. It adds a separate override that forces the wire high during the probe's low phase, which exercises the low-readback path. Contention in the probe's high phase and inside the high part of a data cell is created by asserting the second node's pull-down at a known sample offset counted from the first probe cycle.

// File: rtl/swb_pkg.sv
package swb_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WAIT,
      ST_PLO,
      ST_PHI,
      ST_TAKE,
      ST_BIT
   } swb_state_e;

   function automatic int unsigned swb_max3(input int unsigned a, input int unsigned b,
                                            input int unsigned c);
      int unsigned m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/swb_sync.sv
module swb_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_i,
   output logic sync_o
);
   logic [STAGES-1:0] stg_q;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg_q[0] <= 1'b0;
            else        stg_q[0] <= async_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg_q[i] <= 1'b0;
            else        stg_q[i] <= stg_q[i-1];
         end
      end
   end

   assign sync_o = stg_q[STAGES-1];
endmodule

// File: rtl/swb_readback.sv
module swb_readback #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic drive_i,
   input  logic act_i,
   input  logic bus_s_i,
   output logic mism_o
);
   logic [STAGES-1:0] exp_q;
   logic [STAGES-1:0] act_q;

   for (genvar i = 0; i < STAGES; i++) begin : g_pipe
      if (i == 0) begin : g_head
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               exp_q[0] <= 1'b0;
               act_q[0] <= 1'b0;
            end else begin
               exp_q[0] <= drive_i;
               act_q[0] <= act_i;
            end
         end
      end else begin : g_tail
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               exp_q[i] <= 1'b0;
               act_q[i] <= 1'b0;
            end else begin
               exp_q[i] <= exp_q[i-1];
               act_q[i] <= act_q[i-1];
            end
         end
      end
   end

   // Wire level expected = not(driven low); equality with the drive flag is a mismatch.
   assign mism_o = act_q[STAGES-1] & act_i & (bus_s_i == exp_q[STAGES-1]);
endmodule

// File: rtl/swb_rz_ser.sv
module swb_rz_ser #(
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned UNIT_CYC = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic              run_i,
   output logic              low_o,
   output logic              last_o
);
   localparam int unsigned CELL_CYC = 3 * UNIT_CYC;
   localparam int unsigned CW       = $clog2(CELL_CYC + 1);
   localparam int unsigned BW       = (DATA_W > 1) ? $clog2(DATA_W) : 1;

   logic [DATA_W-1:0] sh_q;
   logic [CW-1:0]     cell_q;
   logic [BW-1:0]     left_q;
   logic [CW-1:0]     low_len;
   logic              cell_end;

   assign low_len  = sh_q[DATA_W-1] ? CW'(UNIT_CYC) : CW'(2 * UNIT_CYC);
   assign cell_end = (cell_q == CW'(CELL_CYC - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q   <= '0;
         cell_q <= '0;
         left_q <= '0;
      end else if (load_i) begin
         sh_q   <= data_i;
         cell_q <= '0;
         left_q <= BW'(DATA_W - 1);
      end else if (run_i) begin
         if (cell_end) begin
            cell_q <= '0;
            sh_q   <= sh_q << 1;
            if (left_q != '0) left_q <= left_q - 1'b1;
         end else begin
            cell_q <= cell_q + 1'b1;
         end
      end
   end

   assign low_o  = run_i & (cell_q < low_len);
   assign last_o = run_i & cell_end & (left_q == '0);
endmodule

// File: rtl/swb_tx.sv
module swb_tx
   import swb_pkg::*;
#(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned IDLE_CYC    = 6,
   parameter int unsigned PRIO_CYC    = 4,
   parameter int unsigned PROBE_CYC   = 3,
   parameter int unsigned TAKE_CYC    = 12,
   parameter int unsigned RX_MIN_TAKE = 5,
   parameter int unsigned UNIT_CYC    = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic              bus_i,
   output logic              drive_low_o,
   output logic              busy_o,
   output logic              done_o,
   output logic              lost_o
);
   localparam int unsigned WAIT_TOT = IDLE_CYC + PRIO_CYC;
   localparam int unsigned MAX_CNT  = swb_max3(WAIT_TOT, PROBE_CYC, TAKE_CYC);
   localparam int unsigned CNT_W    = $clog2(MAX_CNT + 1);

   if (DATA_W < 1) begin : g_bad_width
      $error("swb_tx: DATA_W must be at least 1");
   end
   if (SYNC_STAGES < 1) begin : g_bad_sync
      $error("swb_tx: SYNC_STAGES must be at least 1");
   end
   if (TAKE_CYC <= 2 * RX_MIN_TAKE) begin : g_bad_take
      $error("swb_tx: TAKE_CYC must exceed twice RX_MIN_TAKE");
   end
   if (PROBE_CYC <= SYNC_STAGES) begin : g_bad_probe
      $error("swb_tx: PROBE_CYC must exceed SYNC_STAGES so both readbacks are seen");
   end
   if (UNIT_CYC <= SYNC_STAGES) begin : g_bad_unit
      $error("swb_tx: UNIT_CYC must exceed SYNC_STAGES so every cell edge is checked");
   end
   if (WAIT_TOT < 1) begin : g_bad_wait
      $error("swb_tx: idle plus priority wait must be at least 1");
   end

   swb_state_e       state_q;
   logic [CNT_W-1:0] cnt_q;
   logic             done_q, lost_q;
   logic             bus_s, mism, active;
   logic             ser_low, ser_last, ser_load, ser_run;

   swb_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (bus_i),
      .sync_o  (bus_s)
   );

   assign active = (state_q == ST_PLO) || (state_q == ST_PHI) ||
                   (state_q == ST_TAKE) || (state_q == ST_BIT);

   assign ser_load = (state_q == ST_IDLE) && start_i;
   assign ser_run  = (state_q == ST_BIT);

   swb_rz_ser #(.DATA_W(DATA_W), .UNIT_CYC(UNIT_CYC)) u_ser (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (ser_load),
      .data_i (data_i),
      .run_i  (ser_run),
      .low_o  (ser_low),
      .last_o (ser_last)
   );

   assign drive_low_o = (state_q == ST_PLO) || (state_q == ST_TAKE) || ser_low;

   swb_readback #(.STAGES(SYNC_STAGES)) u_rb (
      .clk     (clk),
      .rst_n   (rst_n),
      .drive_i (drive_low_o),
      .act_i   (active),
      .bus_s_i (bus_s),
      .mism_o  (mism)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         done_q  <= 1'b0;
         lost_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         lost_q <= 1'b0;
         if (mism) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            lost_q  <= 1'b1;
         end else begin
            unique case (state_q)
               ST_IDLE: begin
                  if (start_i) begin
                     state_q <= ST_WAIT;
                     cnt_q   <= '0;
                  end
               end
               ST_WAIT: begin
                  if (!bus_s) begin
                     cnt_q <= '0;
                  end else if (cnt_q == CNT_W'(WAIT_TOT - 1)) begin
                     state_q <= ST_PLO;
                     cnt_q   <= '0;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
               ST_PLO: begin
                  if (cnt_q == CNT_W'(PROBE_CYC - 1)) begin
                     state_q <= ST_PHI;
                     cnt_q   <= '0;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
               ST_PHI: begin
                  if (cnt_q == CNT_W'(PROBE_CYC - 1)) begin
                     state_q <= ST_TAKE;
                     cnt_q   <= '0;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
               ST_TAKE: begin
                  if (cnt_q == CNT_W'(TAKE_CYC - 1)) begin
                     state_q <= ST_BIT;
                     cnt_q   <= '0;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
               ST_BIT: begin
                  if (ser_last) begin
                     state_q <= ST_IDLE;
                     done_q  <= 1'b1;
                  end
               end
               default: state_q <= ST_IDLE;
            endcase
         end
      end
   end

   assign busy_o = (state_q != ST_IDLE);
   assign done_o = done_q;
   assign lost_o = lost_q;
endmodule

// File: rtl/swb_tx_chk.sv
module swb_tx_chk #(
   parameter int unsigned IDLE_CYC  = 6,
   parameter int unsigned PRIO_CYC  = 4,
   parameter int unsigned TAKE_CYC  = 12,
   parameter int unsigned UNIT_CYC  = 3
) (
   input logic clk,
   input logic rst_n,
   input logic bus_i,
   input logic drive_low_o,
   input logic busy_o,
   input logic done_o,
   input logic lost_o
);
   localparam int unsigned WAIT_TOT = IDLE_CYC + PRIO_CYC;
   localparam int unsigned LOW_MAX  = TAKE_CYC + 2 * UNIT_CYC;
   localparam int unsigned RW       = $clog2(WAIT_TOT + LOW_MAX + 2);

   logic [RW-1:0] hi_run_q, low_run_q;
   logic          probed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_run_q  <= '0;
         low_run_q <= '0;
         probed_q  <= 1'b0;
      end else begin
         if (!bus_i)                            hi_run_q <= '0;
         else if (hi_run_q < RW'(WAIT_TOT + 1)) hi_run_q <= hi_run_q + 1'b1;
         if (!drive_low_o)                      low_run_q <= '0;
         else if (low_run_q < RW'(LOW_MAX + 1)) low_run_q <= low_run_q + 1'b1;
         if (!busy_o)           probed_q <= 1'b0;
         else if (drive_low_o)  probed_q <= 1'b1;
      end
   end

   assert_idle_before_probe_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (drive_low_o && !probed_q) |-> (hi_run_q >= RW'(WAIT_TOT)));

   assert_no_drive_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> !drive_low_o);

   assert_low_bounded_R5: assert property (@(posedge clk) disable iff (!rst_n)
      low_run_q <= RW'(LOW_MAX));

   assert_done_released_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!drive_low_o && !busy_o && $past(!drive_low_o)));

   assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   assert_one_outcome_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({done_o, lost_o}));

   assert_busy_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> (done_o || lost_o));

   assert_lost_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
      lost_o |-> (!drive_low_o && !busy_o));

   assert_lost_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      lost_o |=> !lost_o);
endmodule

bind swb_tx swb_tx_chk #(
   .IDLE_CYC (IDLE_CYC),
   .PRIO_CYC (PRIO_CYC),
   .TAKE_CYC (TAKE_CYC),
   .UNIT_CYC (UNIT_CYC)
) u_swb_tx_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .bus_i       (bus_i),
   .drive_low_o (drive_low_o),
   .busy_o      (busy_o),
   .done_o      (done_o),
   .lost_o      (lost_o)
);

// File: tb/tb_swb_tx.sv
module tb_swb_tx;
   localparam int DW    = 8;
   localparam int IDLE  = 6;
   localparam int PRIO  = 4;
   localparam int PROBE = 3;
   localparam int TAKE  = 12;
   localparam int UNIT  = 3;
   localparam int W     = IDLE + PRIO;
   localparam int LIMIT = 20000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [DW-1:0] data = '0;
   logic          other_low = 1'b0;
   logic          force_hi = 1'b0;
   logic          bus;
   logic          drive_low, busy, done, lost;

   int checks = 0;
   int errors = 0;
   logic exp_seq [0:255];
   int   exp_len;

   always #10 clk = ~clk;

   assign bus = force_hi ? 1'b1 : ~(drive_low | other_low);

   swb_tx #(
      .DATA_W(DW), .SYNC_STAGES(2), .IDLE_CYC(IDLE), .PRIO_CYC(PRIO),
      .PROBE_CYC(PROBE), .TAKE_CYC(TAKE), .RX_MIN_TAKE(5), .UNIT_CYC(UNIT)
   ) dut (
      .clk(clk), .rst_n(rst_n), .start_i(start), .data_i(data), .bus_i(bus),
      .drive_low_o(drive_low), .busy_o(busy), .done_o(done), .lost_o(lost)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic fill(input logic [DW-1:0] d);
      int n = 0;
      for (int i = 0; i < PROBE; i++) begin exp_seq[n] = 1'b1; n++; end
      for (int i = 0; i < PROBE; i++) begin exp_seq[n] = 1'b0; n++; end
      for (int i = 0; i < TAKE; i++)  begin exp_seq[n] = 1'b1; n++; end
      for (int b = DW - 1; b >= 0; b--) begin
         int lo = d[b] ? UNIT : 2 * UNIT;
         for (int c = 0; c < 3 * UNIT; c++) begin
            exp_seq[n] = (c < lo);
            n++;
         end
      end
      exp_len = n;
   endtask

   task automatic pulse_start(input logic [DW-1:0] d);
      start = 1'b1;
      data  = d;
      @(negedge clk);
      start = 1'b0;
      data  = ~d;
   endtask

   task automatic wait_drive();
      while (!drive_low) @(negedge clk);
   endtask

   // R1: reset state
   task automatic t_reset();
      chk("R1", "drive_low after reset", drive_low, 0);
      chk("R1", "busy after reset", busy, 0);
      chk("R1", "done after reset", done, 0);
      chk("R1", "lost after reset", lost, 0);
   endtask

   // R2 R4 R5 R6 R7: full frame, optional start poke mid-frame
   task automatic t_frame(input logic [DW-1:0] d, input bit poke);
      int bad = 0;
      int first_i = -1, first_a = 0, first_e = 0;
      fill(d);
      @(negedge clk);
      pulse_start(d);
      chk("R2", "busy after start", busy, 1);
      wait_drive();
      for (int i = 0; i < exp_len; i++) begin
         if (drive_low != exp_seq[i]) begin
            bad++;
            if (first_i < 0) begin first_i = i; first_a = drive_low; first_e = exp_seq[i]; end
         end
         if (poke && i == 4)  begin start = 1'b1; data = ~d; end
         if (poke && i == 5)  start = 1'b0;
         @(negedge clk);
      end
      if (bad != 0)
         $display("FAIL R6 waveform first mismatch at sample %0d actual=%0d expected=%0d",
                  first_i, first_a, first_e);
      chk(poke ? "R2" : "R6", "waveform mismatching samples (R4 R5 R6)", bad, 0);
      chk("R7", "done after last cell", done, 1);
      chk("R7", "busy after last cell", busy, 0);
      chk("R7", "drive after last cell", drive_low, 0);
      @(negedge clk);
      chk("R7", "done pulse width", done, 0);
      if (poke) begin
         repeat (3 * W) @(negedge clk);
         chk("R2", "no extra attempt from ignored start", busy, 0);
      end
   endtask

   // R3: held low bus blocks the probe, a glitch restarts the idle count
   task automatic t_wait();
      int k = 0;
      fill(8'h5A);
      @(negedge clk);
      other_low = 1'b1;
      pulse_start(8'h5A);
      repeat (3 * W) @(negedge clk);
      chk("R3", "no drive while wire held low", drive_low, 0);
      chk("R3", "still busy while wire held low", busy, 1);
      other_low = 1'b0;
      repeat (W - 3) @(negedge clk);
      other_low = 1'b1;
      repeat (2) @(negedge clk);
      chk("R3", "no probe before idle run complete", drive_low, 0);
      other_low = 1'b0;
      while (!drive_low && k < 4 * W) begin
         @(negedge clk);
         k++;
      end
      chk("R3", "idle run latency in window", (k >= W + 1 && k <= W + 3), 1);
      while (!done && k < 400) begin @(negedge clk); k++; end
      chk("R7", "frame completes after wait", done, 1);
      @(negedge clk);
   endtask

   // R8: contention at a given sample offset from first probe cycle
   task automatic t_lost(input logic [DW-1:0] d, input int offset, input bit use_force);
      int k = 0;
      @(negedge clk);
      pulse_start(d);
      wait_drive();
      repeat (offset) @(negedge clk);
      if (use_force) force_hi = 1'b1; else other_low = 1'b1;
      while (!lost && k < 6) begin @(negedge clk); k++; end
      chk("R8", "lost reported", lost, 1);
      chk("R8", "drive released with lost", drive_low, 0);
      chk("R8", "busy cleared with lost", busy, 0);
      force_hi  = 1'b0;
      other_low = 1'b0;
      @(negedge clk);
      chk("R8", "lost pulse width", lost, 0);
      k = 0;
      for (int i = 0; i < 4 * W; i++) begin
         if (drive_low || busy) k++;
         @(negedge clk);
      end
      chk("R8", "no retry after lost", k, 0);
   endtask

   initial begin
      repeat (LIMIT) @(posedge clk);
      errors++;
      $display("FAIL R7 watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2 * W) @(negedge clk);
      t_reset();
      t_frame(8'hA5, 1'b0);
      t_frame(8'h00, 1'b0);
      t_frame(8'hFF, 1'b0);
      t_frame(8'h3C, 1'b1);
      t_wait();
      t_lost(8'h80, PROBE, 1'b0);                       // probe high phase
      t_lost(8'h80, 0, 1'b1);                           // probe low phase, wire forced high
      t_lost(8'h80, 2 * PROBE + TAKE + UNIT, 1'b0);     // high part of first data cell
      t_frame(8'h96, 1'b0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule